// File: doc/BRIEF.md
# Weight-Stationary Systolic Matrix Multiplier

This block is a square grid of N×N multiply-accumulate cells that multiplies a stream of signed 8-bit activation vectors by a resident N×N tile of signed 8-bit weights. Each cell keeps its weight in place. Activations enter at the left edge and step one cell to the right on every clock. Partial sums step one cell downward and leave the bottom edge as 32-bit column results. Activation row k is delayed by k cycles before it enters the grid, so the diagonal wavefronts line up. An output stage removes that skew again, which means each beat delivers one complete result row.

Each cell holds a second, shadow copy of its weight. The next tile can be written into the shadow copies one row at a time while the current tile is still computing. A single commit strobe then moves every shadow weight into the active copy on the same edge. The block refuses a commit while any activation wavefront could still read the active weights, so a tile swap can never corrupt a result in flight. Every operand enters the grid once and after that only moves between neighbouring cells.

Top module: `wsmm_array`

## Requirements
- R1: For each activation beat, output column j (bits `res_data[j*32 +: 32]`) equals the sum over k of a[k]·W[k][j]. The activation element a[k] is taken from `act_data[k*8 +: 8]`. The weight W[k][j] is lane j (`wld_data[j*8 +: 8]`) of the row written with `wld_row = k`. All operands are two's-complement signed, and the sum wraps at 32 bits.
- R2: A beat sampled on clock edge t produces exactly one result. That result is presented with `res_valid` high from edge t+2N−2 until the next edge. Results come out in the order the beats were sampled, and `res_valid` is low at all other times.
- R3: Writing shadow weights with `wld_en` does not change any result until a commit is accepted. This holds even when the writes happen in the same cycles as activation beats.
- R4: An accepted commit copies all N×N shadow weights into the active weights on its edge. Every beat sampled after that edge uses the new tile.
- R5: The block ignores a commit when `act_valid` is high in the same cycle, or when a beat was sampled on any of the previous 2N−3 edges. An ignored commit leaves the active weights unchanged. A commit exactly 2N−2 edges after the last beat is accepted.
- R6: When a commit is accepted on the same edge as a shadow write, the active weights receive the shadow contents from before that write.
- R7: Reset clears `res_valid`, every partial sum and output register (so `res_data` reads zero), and both weight copies in every cell. A commit straight after reset therefore produces all-zero results.
- R8: The extreme operand values −128 and 127 are handled as signed numbers in every product, including −128·−128 = 16384 and sums of such products.
- R9: Beats presented on consecutive cycles produce results on consecutive cycles, with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| act_valid | input | 1 | Activation beat present this cycle |
| act_data | input | N*AW | Activation vector, element k drives grid row k |
| wld_en | input | 1 | Write one row of shadow weights |
| wld_row | input | RW | Grid row receiving the shadow write |
| wld_data | input | N*AW | Shadow weights for that row, lane j for column j |
| w_commit | input | 1 | Request to copy shadow weights into active weights |
| res_valid | output | 1 | Result row present this cycle |
| res_data | output | N*ACCW | Result row, column j in lane j |

## Verification
The bound checker checks the commit rules on every cycle. An accepted commit must never coincide with an incoming beat. It must move the shadow tile exactly into the active tile, and the active tile must stay unchanged on every edge without an accepted commit. The checker also checks that no result appears without a beat outstanding, and that the number of outstanding beats stays within the pipeline depth. The arithmetic cannot be checked that way. Signed products at the extreme values, exact latency, ordering, isolation of shadow writes from running results, and the boundary between an ignored and an accepted commit only show up in the bench's scenarios, where each result row is compared with a reference product.

// File: rtl/wsmm_pkg.sv
package wsmm_pkg;

   // Edges from the sampling edge of a beat to the edge presenting its result.
   function automatic int wsmm_latency(input int n);
      return 2 * n - 2;
   endfunction

   // Width of a row index for an n-row grid.
   function automatic int wsmm_idx_w(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/wsmm_delay.sv
module wsmm_delay #(
   parameter int W     = 8,
   parameter int DEPTH = 0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (DEPTH < 0) begin : g_bad_depth
         $error("wsmm_delay: DEPTH must not be negative");
      end

      if (DEPTH == 0) begin : g_wire
         logic unused_ctl;
         assign unused_ctl = clk ^ rst_n;
         assign q = d;
      end else begin : g_regs
         logic [W-1:0] stg [DEPTH];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) stg[i] <= '0;
            end else begin
               stg[0] <= d;
               for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
            end
         end
         assign q = stg[DEPTH-1];
      end
   endgenerate

endmodule

// File: rtl/wsmm_cell.sv
module wsmm_cell #(
   parameter int AW   = 8,
   parameter int ACCW = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [AW-1:0]   a_in,
   input  logic [ACCW-1:0] ps_in,
   input  logic            sh_we,
   input  logic [AW-1:0]   sh_d,
   input  logic            commit,
   output logic [AW-1:0]   a_out,
   output logic [ACCW-1:0] ps_out,
   output logic [AW-1:0]   w_act_o,
   output logic [AW-1:0]   w_shd_o
);

   logic [AW-1:0]          a_q;
   logic [ACCW-1:0]        ps_q;
   logic [AW-1:0]          w_act;
   logic [AW-1:0]          w_shd;
   logic signed [2*AW-1:0] prod;
   logic [ACCW-1:0]        prod_ext;

   always_comb begin
      prod     = $signed(a_in) * $signed(w_act);
      prod_ext = ACCW'(prod);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_q   <= '0;
         ps_q  <= '0;
         w_act <= '0;
         w_shd <= '0;
      end else begin
         a_q  <= a_in;
         ps_q <= ps_in + prod_ext;
         if (sh_we)  w_shd <= sh_d;
         if (commit) w_act <= w_shd;
      end
   end

   assign a_out   = a_q;
   assign ps_out  = ps_q;
   assign w_act_o = w_act;
   assign w_shd_o = w_shd;

endmodule

// File: rtl/wsmm_ctrl.sv
module wsmm_ctrl #(
   parameter int N  = 4,
   parameter int RW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          act_valid,
   input  logic          wld_en,
   input  logic [RW-1:0] wld_row,
   input  logic          w_commit,
   output logic          res_valid,
   output logic          commit_take,
   output logic [N-1:0]  row_we
);

   localparam int VD = wsmm_pkg::wsmm_latency(N) + 1;

   logic [VD-1:0] vq;
   logic          busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vq <= '0;
      else        vq <= {vq[VD-2:0], act_valid};
   end

   // A beat still reads active weights until its last column edge.
   assign busy        = act_valid | (|vq[VD-3:0]);
   assign commit_take = w_commit & ~busy;
   assign res_valid   = vq[VD-1];

   generate
      for (genvar k = 0; k < N; k++) begin : g_row_dec
         assign row_we[k] = wld_en && (wld_row == RW'(k));
      end
   endgenerate

endmodule

// File: rtl/wsmm_array.sv
module wsmm_array #(
   parameter  int N    = 4,
   parameter  int AW   = 8,
   parameter  int ACCW = 32,
   localparam int RW   = wsmm_pkg::wsmm_idx_w(N)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            act_valid,
   input  logic [N*AW-1:0] act_data,
   input  logic            wld_en,
   input  logic [RW-1:0]   wld_row,
   input  logic [N*AW-1:0] wld_data,
   input  logic            w_commit,
   output logic            res_valid,
   output logic [N*ACCW-1:0] res_data
);

   generate
      if (N < 2) begin : g_bad_n
         $error("wsmm_array: N must be at least 2");
      end
      if (ACCW < 2 * AW) begin : g_bad_accw
         $error("wsmm_array: ACCW must hold a full product");
      end
   endgenerate

   logic          commit_take;
   logic [N-1:0]  row_we;

   logic [AW-1:0]   a_bus  [N][N+1];
   logic [ACCW-1:0] ps_bus [N+1][N];
   logic [N*N*AW-1:0] w_act_flat;
   logic [N*N*AW-1:0] w_shd_flat;
   logic [N-1:0]    unused_east;

   wsmm_ctrl #(.N(N), .RW(RW)) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .act_valid   (act_valid),
      .wld_en      (wld_en),
      .wld_row     (wld_row),
      .w_commit    (w_commit),
      .res_valid   (res_valid),
      .commit_take (commit_take),
      .row_we      (row_we)
   );

   generate
      // Input skew: row k waits k cycles; idle cycles feed zeros.
      for (genvar k = 0; k < N; k++) begin : g_skew
         logic [AW-1:0] a_gated;
         assign a_gated = act_valid ? act_data[k*AW +: AW] : '0;
         wsmm_delay #(.W(AW), .DEPTH(k)) u_skew (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (a_gated),
            .q     (a_bus[k][0])
         );
         assign unused_east[k] = ^a_bus[k][N];
      end

      for (genvar j = 0; j < N; j++) begin : g_top
         assign ps_bus[0][j] = '0;
      end

      for (genvar k = 0; k < N; k++) begin : g_r
         for (genvar j = 0; j < N; j++) begin : g_c
            wsmm_cell #(.AW(AW), .ACCW(ACCW)) u_cell (
               .clk     (clk),
               .rst_n   (rst_n),
               .a_in    (a_bus[k][j]),
               .ps_in   (ps_bus[k][j]),
               .sh_we   (row_we[k]),
               .sh_d    (wld_data[j*AW +: AW]),
               .commit  (commit_take),
               .a_out   (a_bus[k][j+1]),
               .ps_out  (ps_bus[k+1][j]),
               .w_act_o (w_act_flat[(k*N+j)*AW +: AW]),
               .w_shd_o (w_shd_flat[(k*N+j)*AW +: AW])
            );
         end
      end

      // Output deskew: column j waits N-1-j cycles so a row leaves together.
      for (genvar j = 0; j < N; j++) begin : g_deskew
         wsmm_delay #(.W(ACCW), .DEPTH(N - 1 - j)) u_dsk (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (ps_bus[N][j]),
            .q     (res_data[j*ACCW +: ACCW])
         );
      end
   endgenerate

endmodule

// File: rtl/wsmm_chk.sv
module wsmm_chk #(
   parameter int N  = 4,
   parameter int AW = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              act_valid,
   input logic              res_valid,
   input logic              commit_take,
   input logic [N*N*AW-1:0] w_act_flat,
   input logic [N*N*AW-1:0] w_shd_flat
);

   localparam int MAXF = 2 * N - 1;

   int unsigned inflight;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) inflight <= 0;
      else        inflight <= inflight + (act_valid ? 1 : 0) - (res_valid ? 1 : 0);
   end

   // R5: no tile swap while a beat is entering
   assert_commit_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      commit_take |-> !act_valid);

   // R4: accepted commit transfers the shadow tile exactly
   assert_commit_copy_R4: assert property (@(posedge clk) disable iff (!rst_n)
      commit_take |=> (w_act_flat == $past(w_shd_flat)));

   // R3: active tile only moves on an accepted commit
   assert_weights_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !commit_take |=> $stable(w_act_flat));

   // R2: a result needs an outstanding beat
   assert_valid_has_beat_R2: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> (inflight != 0));

   // R2: outstanding beats never exceed the pipeline depth
   assert_inflight_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      inflight <= MAXF);

endmodule

bind wsmm_array wsmm_chk #(.N(N), .AW(AW)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .act_valid   (act_valid),
   .res_valid   (res_valid),
   .commit_take (commit_take),
   .w_act_flat  (w_act_flat),
   .w_shd_flat  (w_shd_flat)
);

// File: tb/wsmm_array_bench.sv
module wsmm_array_bench;

   localparam int N    = 4;
   localparam int AW   = 8;
   localparam int ACCW = 32;
   localparam int RW   = $clog2(N);
   localparam int LAT  = 2 * N - 1;
   localparam int GAP  = 2 * N - 2;

   typedef struct {
      logic [N*ACCW-1:0] row;
      int                stamp;
      string             tag;
   } item_t;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              act_valid = 1'b0;
   logic [N*AW-1:0]   act_data = '0;
   logic              wld_en = 1'b0;
   logic [RW-1:0]     wld_row = '0;
   logic [N*AW-1:0]   wld_data = '0;
   logic              w_commit = 1'b0;
   logic              res_valid;
   logic [N*ACCW-1:0] res_data;

   int    cyc = 0;
   int    checks = 0;
   int    fails = 0;
   int    last_send = -1000;
   bit    done = 1'b0;
   string cur_tag = "R7";
   item_t sbq [$];
   item_t mon_it;
   logic [N*AW-1:0] shd_m [N];
   logic [N*AW-1:0] act_m [N];
   logic [N*AW-1:0] tile [N];

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   wsmm_array #(.N(N), .AW(AW), .ACCW(ACCW)) u_wsmm_array (
      .clk       (clk),
      .rst_n     (rst_n),
      .act_valid (act_valid),
      .act_data  (act_data),
      .wld_en    (wld_en),
      .wld_row   (wld_row),
      .wld_data  (wld_data),
      .w_commit  (w_commit),
      .res_valid (res_valid),
      .res_data  (res_data)
   );

   function automatic logic [7:0] rnd8();
      case ($urandom % 6)
         0:       return 8'h80;
         1:       return 8'h7f;
         default: return 8'($urandom);
      endcase
   endfunction

   function automatic logic [N*AW-1:0] rnd_row();
      logic [N*AW-1:0] r;
      for (int i = 0; i < N; i++) r[i*AW +: AW] = rnd8();
      return r;
   endfunction

   // Reference product against the bench's model of the active tile (R1)
   function automatic logic [N*ACCW-1:0] ref_row(input logic [N*AW-1:0] a);
      logic [N*ACCW-1:0] r;
      for (int j = 0; j < N; j++) begin
         int acc = 0;
         for (int k = 0; k < N; k++)
            acc = acc + $signed(a[k*AW +: AW]) * $signed(act_m[k][j*AW +: AW]);
         r[j*ACCW +: ACCW] = acc;
      end
      return r;
   endfunction

   // Driver: one cycle of stimulus; pushes expected rows to the scoreboard
   task automatic step(input logic av, input logic [N*AW-1:0] ad,
                       input logic le, input int lr, input logic [N*AW-1:0] ld,
                       input logic cm);
      item_t it;
      act_valid = av;
      act_data  = ad;
      wld_en    = le;
      wld_row   = lr[RW-1:0];
      wld_data  = ld;
      w_commit  = cm;
      if (av) begin
         it.row   = ref_row(ad);
         it.stamp = cyc + LAT;
         it.tag   = cur_tag;
         sbq.push_back(it);
      end
      // R5 acceptance rule, R6 pre-write shadow copy
      if (cm && !av && (cyc - last_send >= GAP))
         for (int k = 0; k < N; k++) act_m[k] = shd_m[k];
      if (le) shd_m[lr] = ld;
      if (av) last_send = cyc;
      @(negedge clk);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(1'b0, '0, 1'b0, 0, '0, 1'b0);
   endtask

   task automatic send(input logic [N*AW-1:0] a);
      step(1'b1, a, 1'b0, 0, '0, 1'b0);
   endtask

   task automatic load_tile();
      for (int r = 0; r < N; r++) step(1'b0, '0, 1'b1, r, tile[r], 1'b0);
   endtask

   task automatic commit();
      step(1'b0, '0, 1'b0, 0, '0, 1'b1);
   endtask

   // Monitor: pops and compares as results appear
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (res_valid) begin
            checks++;
            if (sbq.size() == 0) begin
               fails++;
               $display("FAIL R2: result at cycle %0d actual %h expected none", cyc, res_data);
            end else begin
               mon_it = sbq.pop_front();
               if (mon_it.stamp != cyc) begin
                  fails++;
                  $display("FAIL R2: result cycle actual %0d expected %0d", cyc, mon_it.stamp);
               end
               checks++;
               if (res_data !== mon_it.row) begin
                  fails++;
                  $display("FAIL %s: result actual %h expected %h", mon_it.tag, res_data, mon_it.row);
               end
            end
         end else if (sbq.size() > 0 && sbq[0].stamp <= cyc) begin
            checks++;
            fails++;
            mon_it = sbq.pop_front();
            $display("FAIL R2: missing result, actual none at %0d expected at %0d", cyc, mon_it.stamp);
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("  [TB] %0d tests run, %0d failed", checks, fails);
         $finish;
      end
   end

   initial begin
      for (int k = 0; k < N; k++) begin
         shd_m[k] = '0;
         act_m[k] = '0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R7: outputs cleared by reset
      checks++;
      if (res_valid !== 1'b0 || res_data !== '0) begin
         fails++;
         $display("FAIL R7: after reset actual valid=%b data=%h expected 0/0", res_valid, res_data);
      end

      // R7: both weight copies cleared, so commit then stream gives zeros
      cur_tag = "R7";
      commit();
      send(rnd_row());
      send({N{8'h80}});
      idle(2);

      // R1: random tile with corners, one result per beat
      for (int r = 0; r < N; r++) tile[r] = rnd_row();
      load_tile();
      commit();
      cur_tag = "R1";
      for (int i = 0; i < 4; i++) begin
         send(rnd_row());
         idle(1);
      end

      // R9: back-to-back stream
      cur_tag = "R9";
      for (int i = 0; i < 8; i++) send(rnd_row());

      // R3: shadow writes during streaming do not touch results
      cur_tag = "R3";
      tile[0] = {N{8'h80}};
      tile[1] = {N{8'h7f}};
      tile[2] = {8'h80, 8'h7f, 8'h80, 8'h7f};
      tile[3] = rnd_row();
      for (int r = 0; r < N; r++) step(1'b1, rnd_row(), 1'b1, r, tile[r], 1'b0);

      // R5: commit one edge too early is ignored
      idle(GAP - 2);
      commit();
      cur_tag = "R5";
      send(rnd_row());
      send(rnd_row());

      // R4: commit exactly at the allowed gap is accepted
      idle(GAP - 1);
      commit();
      cur_tag = "R4";
      send(rnd_row());

      // R8: extreme operands against a corner-heavy tile
      cur_tag = "R8";
      send({N{8'h80}});
      send({N{8'h7f}});
      send({8'h7f, 8'h80, 8'h7f, 8'h80});
      send({8'h80, 8'h80, 8'h7f, 8'h7f});

      // R5: commit alongside a beat is ignored though shadow differs
      cur_tag = "R5";
      for (int r = 0; r < N; r++) begin
         tile[r] = rnd_row();
         step(1'b1, rnd_row(), 1'b1, r, tile[r], 1'b0);
      end
      step(1'b1, rnd_row(), 1'b0, 0, '0, 1'b1);
      send(rnd_row());

      // R6: commit and write on the same edge take the old shadow row
      idle(GAP);
      step(1'b0, '0, 1'b1, 0, rnd_row(), 1'b1);
      cur_tag = "R6";
      send(rnd_row());
      send({N{8'h80}});

      idle(2 * N + 2);
      checks++;
      if (sbq.size() != 0) begin
         fails++;
         $display("FAIL R2: pending results actual %0d expected 0", sbq.size());
      end
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
   end

endmodule